// File: doc/BRIEF.md
# Page Translation Unit with Associative Cache and Table Walk

This block turns a logical address from the processor into a physical address. The logical address splits into two fields. The page number is the upper `LA_W-OFF_W` bits. The offset within the page is the low `OFF_W` bits. The block keeps a small fully associative store of page-to-frame mappings. Every stored tag is compared with the incoming page number in parallel. On a match the frame number is joined to the unchanged offset and the response is returned in the same cycle.

When no entry matches, the request is held with `req_ready` low. The block then issues a single word read to memory. The read address is the page-table base register plus the page number. The frame number is taken from the low `FR_W` bits of the returned word and used for the response. The new mapping is written into the store through a round-robin victim pointer. That pointer passes over any entry that software has pinned.

Software can reload the base register when it switches process. Doing so drops every mapping that is not pinned. Pinned entries survive both replacement and reload. If every entry is pinned, a translation found by a walk is still returned, but it is not kept.

Top module: `addr_xlate_unit`

## Requirements
- R1: With the block idle, a request whose page matches a valid entry gives `req_ready`, `rsp_valid` and `rsp_hit` high in the same cycle. `rsp_paddr` equals {stored frame, request offset}, and no memory read is issued.
- R2: A request that matches no entry drives `req_ready` low. One cycle later `mem_rd_en` is high for exactly one cycle, with `mem_rd_addr` = base register + page number (zero-extended).
- R3: In the cycle after the one in which `mem_rd_valid` is sampled high, the held request completes. In that cycle `rsp_valid` = 1, `rsp_hit` = 0 and `rsp_paddr` = {`mem_rd_data[FR_W-1:0]`, offset}. Upper bits of the memory word are ignored.
- R4: After a walk, a later request to the same page hits, unless every entry was pinned.
- R5: After reset, new mappings go into entries 0, 1, 2 … in order and wrap around. Once the store is full, the oldest mapping in round-robin order is evicted.
- R6: `wire_wr_en` sets the pin bit of entry `wire_wr_idx` to `wire_wr_val`. The victim pointer never selects a pinned entry, so a pinned mapping keeps hitting however many misses follow.
- R7: A cycle with `base_wr_en` high loads `base_wr_data` into the base register and invalidates every entry that is not pinned. Later walks use the new base.
- R8: When all entries are pinned, a miss still completes with the walked frame, but nothing is installed. A repeat of the same page walks again.
- R9: After reset, `rsp_valid`, `req_ready` and `mem_rd_en` are low, all entries are invalid and unpinned, and the base register holds `BASE_RST`.
- R10: Only one walk is outstanding at a time. `mem_rd_en` is not raised again, and no response is produced, until the pending read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present; held until `req_ready` |
| req_laddr | input | LA_W | Logical address |
| req_ready | output | 1 | Request is completed this cycle |
| rsp_valid | output | 1 | `rsp_paddr` is valid this cycle |
| rsp_paddr | output | FR_W+OFF_W | Physical address {frame, offset} |
| rsp_hit | output | 1 | Response came from the associative store |
| mem_rd_en | output | 1 | Page-table read strobe (one cycle) |
| mem_rd_addr | output | MEM_AW | Word address of the page-table entry |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | MEM_DW | Page-table entry; frame in the low FR_W bits |
| base_wr_en | input | 1 | Load the base register and flush unpinned entries |
| base_wr_data | input | MEM_AW | New page-table base |
| wire_wr_en | input | 1 | Update one pin bit |
| wire_wr_idx | input | IDX_W | Entry whose pin bit is written |
| wire_wr_val | input | 1 | New pin value |

## Verification
A hit is combinational, so its response is sampled one time unit after the falling edge of the cycle in which the request is driven, with zero wait cycles. A miss raises `mem_rd_en` one edge after the request. The response is due in the cycle right after the edge at which the bench memory's `mem_rd_valid` was high. The bench records that flag at every rising edge, and at the response it checks that the flag was set at the edge just before. It also counts memory reads per request, so that each hit shows zero reads and each miss exactly one read at the expected address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } walk_state_t;
endpackage

// File: rtl/xlate_tag_array.sv
module xlate_tag_array #(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 20,
  parameter int FR_W    = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               hit,
  output logic [FR_W-1:0]    hit_frame,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [PAGE_W-1:0]  ins_page,
  input  logic [FR_W-1:0]    ins_frame,
  input  logic               flush_en,
  input  logic               pin_en,
  input  logic [IDX_W-1:0]   pin_idx,
  input  logic               pin_val,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] pinned_o
);
  logic [PAGE_W-1:0]  tag_q   [ENTRIES];
  logic [FR_W-1:0]    frame_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] pinned_q;
  logic [ENTRIES-1:0] match;

  // parallel tag comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_page);
  end

  always_comb begin
    hit       = 1'b0;
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit       = 1'b1;
        hit_frame = hit_frame | frame_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      pinned_q <= '0;
    end else begin
      if (flush_en) begin
        valid_q <= valid_q & pinned_q;
      end else if (ins_en) begin
        valid_q[ins_idx] <= 1'b1;
      end
      if (pin_en) begin
        pinned_q[pin_idx] <= pin_val;
      end
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (ins_en && !flush_en) begin
      tag_q[ins_idx]   <= ins_page;
      frame_q[ins_idx] <= ins_frame;
    end
  end

  assign valid_o  = valid_q;
  assign pinned_o = pinned_q;
endmodule

// File: rtl/xlate_victim_sel.sv
module xlate_victim_sel #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] pinned,
  input  logic [IDX_W-1:0]   ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               found
);
  // first unpinned entry at or after ptr, circular
  always_comb begin
    victim = ptr;
    found  = 1'b0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= ENTRIES) idx = idx - ENTRIES;
      if (!pinned[idx]) begin
        victim = IDX_W'(idx);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit #(
  parameter int ENTRIES  = 8,
  parameter int LA_W     = 32,
  parameter int OFF_W    = 12,
  parameter int FR_W     = 20,
  parameter int MEM_AW   = 32,
  parameter int MEM_DW   = 32,
  parameter logic [MEM_AW-1:0] BASE_RST = '0,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int PAGE_W  = LA_W - OFF_W,
  localparam int PA_W    = FR_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [MEM_DW-1:0] mem_rd_data,
  input  logic              base_wr_en,
  input  logic [MEM_AW-1:0] base_wr_data,
  input  logic              wire_wr_en,
  input  logic [IDX_W-1:0]  wire_wr_idx,
  input  logic              wire_wr_val
);
  import xlate_pkg::*;

  walk_state_t        state_q;
  logic [MEM_AW-1:0]  base_q;
  logic [FR_W-1:0]    walk_frame_q;
  logic [IDX_W-1:0]   rr_ptr_q;
  logic               rd_en_q;
  logic [MEM_AW-1:0]  rd_addr_q;

  logic [PAGE_W-1:0]  page;
  logic [OFF_W-1:0]   offset;
  logic               hit;
  logic [FR_W-1:0]    hit_frame;
  logic [FR_W-1:0]    fill_frame;
  logic [IDX_W-1:0]   victim;
  logic               victim_ok;
  logic               accept_hit;
  logic               start_walk;
  logic               fill;
  logic               ins_en;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] pinned_vec;

  assign page       = req_laddr[LA_W-1:OFF_W];
  assign offset     = req_laddr[OFF_W-1:0];
  assign fill_frame = FR_W'(mem_rd_data);

  assign accept_hit = (state_q == ST_IDLE) && req_valid && hit;
  assign start_walk = (state_q == ST_IDLE) && req_valid && !hit;
  assign fill       = (state_q == ST_WALK) && mem_rd_valid;
  assign ins_en     = fill && victim_ok;

  xlate_tag_array #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FR_W(FR_W), .IDX_W(IDX_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_page  (page),
    .hit      (hit),
    .hit_frame(hit_frame),
    .ins_en   (ins_en),
    .ins_idx  (victim),
    .ins_page (page),
    .ins_frame(fill_frame),
    .flush_en (base_wr_en),
    .pin_en   (wire_wr_en),
    .pin_idx  (wire_wr_idx),
    .pin_val  (wire_wr_val),
    .valid_o  (valid_vec),
    .pinned_o (pinned_vec)
  );

  xlate_victim_sel #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .pinned(pinned_vec),
    .ptr   (rr_ptr_q),
    .victim(victim),
    .found (victim_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      base_q       <= BASE_RST;
      walk_frame_q <= '0;
      rr_ptr_q     <= '0;
      rd_en_q      <= 1'b0;
      rd_addr_q    <= '0;
    end else begin
      rd_en_q <= 1'b0;
      if (base_wr_en) base_q <= base_wr_data;
      unique case (state_q)
        ST_IDLE: begin
          if (start_walk) begin
            rd_en_q   <= 1'b1;
            rd_addr_q <= base_q + MEM_AW'(page);
            state_q   <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (fill) begin
            walk_frame_q <= fill_frame;
            state_q      <= ST_DONE;
            if (victim_ok) begin
              rr_ptr_q <= (int'(victim) == ENTRIES - 1) ? '0 : victim + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = accept_hit || (state_q == ST_DONE);
  assign rsp_valid   = req_ready;
  assign rsp_hit     = accept_hit;
  assign rsp_paddr   = {(state_q == ST_DONE) ? walk_frame_q : hit_frame, offset};
  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = rd_addr_q;
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               mem_rd_en,
  input logic               mem_rd_valid,
  input logic               base_wr_en,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] pinned_vec
);
  logic walk_busy;

  always_ff @(posedge clk) begin
    if (rst) walk_busy <= 1'b0;
    else if (mem_rd_en) walk_busy <= 1'b1;
    else if (mem_rd_valid) walk_busy <= 1'b0;
  end

  // R1: a response only answers a presented, accepted request
  p_rsp_handshake_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_valid && req_ready));

  // R1: a hit never touches memory
  p_hit_no_read_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !mem_rd_en);

  // R2: read strobe lasts one cycle
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R10: nothing new while a read is pending
  p_one_walk_r10: assert property (@(posedge clk) disable iff (rst)
    walk_busy |-> (!mem_rd_en && !rsp_valid));

  // R3: completion follows returned data
  p_fill_resp_r3: assert property (@(posedge clk) disable iff (rst)
    (walk_busy && mem_rd_valid) |=> (rsp_valid && !rsp_hit));

  // R7: reload leaves only pinned entries valid
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |=> ((valid_vec & ~$past(pinned_vec)) == '0));

  // R6: a valid pinned entry stays valid
  for (genvar g = 0; g < ENTRIES; g++) begin : g_pin
    p_pin_kept_r6: assert property (@(posedge clk) disable iff (rst)
      (valid_vec[g] && pinned_vec[g]) |=> valid_vec[g]);
  end
endmodule

bind addr_xlate_unit xlate_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_valid(mem_rd_valid),
  .base_wr_en  (base_wr_en),
  .valid_vec   (valid_vec),
  .pinned_vec  (pinned_vec)
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_laddr;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_hit;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic        wire_wr_en;
  logic [2:0]  wire_wr_idx;
  logic        wire_wr_val;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlate_unit dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .wire_wr_en(wire_wr_en), .wire_wr_idx(wire_wr_idx), .wire_wr_val(wire_wr_val)
  );

  // page table contents: frame in low 20 bits, junk above
  function automatic logic [19:0] frame_of(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd7 + 32'd5;
    return t[19:0];
  endfunction

  // memory model
  int          rd_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic        vseen = 1'b0;
  logic        mbusy = 1'b0;
  int          mcnt = 0;
  logic [31:0] maddr = '0;

  always @(posedge clk) begin
    vseen        <= mem_rd_valid;
    mem_rd_valid <= 1'b0;
    if (rst) begin
      mbusy <= 1'b0;
    end else if (mem_rd_en) begin
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= mem_rd_addr;
      maddr        <= mem_rd_addr;
      mbusy        <= 1'b1;
      mcnt         <= MEM_LAT;
    end else if (mbusy) begin
      if (mcnt == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= {12'hFFF, frame_of(maddr)};
        mbusy        <= 1'b0;
      end else begin
        mcnt <= mcnt - 1;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] la, input bit exp_hit,
                       input logic [31:0] map_base, input string tag);
    logic [19:0] pg;
    logic [31:0] exp_pa;
    int rd0;
    int waited;
    pg     = la[31:12];
    exp_pa = {frame_of(map_base + {12'h0, pg}), la[11:0]};
    @(negedge clk);
    rd0       = rd_cnt;
    req_valid = 1'b1;
    req_laddr = la;
    #1;
    waited = 0;
    while (!req_ready && waited < 64) begin
      @(negedge clk); #1;
      waited++;
    end
    check({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
    check({tag, " hit flag"}, 64'(rsp_hit), 64'(exp_hit));
    if (exp_hit) begin
      check({tag, " R1 zero wait"}, 64'(waited), 64'd0);
      check({tag, " R1 no read"}, 64'(rd_cnt - rd0), 64'd0);
    end else begin
      check({tag, " R10 one read"}, 64'(rd_cnt - rd0), 64'd1);
      check({tag, " R2 read addr"}, 64'(last_rd_addr), 64'(map_base + {12'h0, pg}));
      check({tag, " R3 due after data"}, 64'(vseen), 64'd1);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  task automatic pin(input int idx, input bit v);
    @(negedge clk);
    wire_wr_en = 1'b1; wire_wr_idx = 3'(idx); wire_wr_val = v;
    @(negedge clk);
    wire_wr_en = 1'b0;
  endtask

  localparam int NV = 6;
  localparam logic [31:0] V_LA [NV] = '{32'h0000_5123, 32'h0000_5FFF, 32'h0003_2004,
                                        32'h0000_5000, 32'hFFFF_F001, 32'h0003_2ABC};
  localparam bit V_HIT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  bit finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_laddr = '0;
    base_wr_en = 1'b0; base_wr_data = '0;
    wire_wr_en = 1'b0; wire_wr_idx = '0; wire_wr_val = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R9 req_ready after reset", 64'(req_ready), 64'd0);
    check("R9 mem_rd_en after reset", 64'(mem_rd_en), 64'd0);

    set_base(32'h0000_1000);
    // table walk: R1 hits, R2/R3 misses, R4 re-reference
    for (int i = 0; i < NV; i++) begin
      xlate(V_LA[i], V_HIT[i], 32'h1000, $sformatf("R4 vec%0d", i));
    end

    // R5: fill entries 3..7, wrap, evict oldest
    for (int p = 0; p < 5; p++) begin
      xlate({12'h000, 20'(32'h100 + p)} << 12, 1'b0, 32'h1000, "R5 fill");
    end
    xlate(32'h0010_5000, 1'b0, 32'h1000, "R5 wrap to entry0");
    xlate(32'h0003_2010, 1'b1, 32'h1000, "R5 entry1 kept");
    xlate(32'h0000_5010, 1'b0, 32'h1000, "R5 evicted page refetch");
    xlate(32'h0003_2020, 1'b0, 32'h1000, "R5 second eviction");

    // R6: pin entries 3,4 (pages 0x100,0x101), churn the rest
    pin(3, 1'b1);
    pin(4, 1'b1);
    xlate(32'h0020_0000, 1'b0, 32'h1000, "R6 miss skips pinned");
    xlate(32'h0010_0abc, 1'b1, 32'h1000, "R6 pinned hit a");
    xlate(32'h0010_1abc, 1'b1, 32'h1000, "R6 pinned hit b");
    xlate(32'h0010_2000, 1'b0, 32'h1000, "R6 unpinned evicted");
    for (int p = 0; p < 6; p++) begin
      xlate({12'h000, 20'(32'h300 + p)} << 12, 1'b0, 32'h1000, "R6 churn");
    end
    xlate(32'h0010_0001, 1'b1, 32'h1000, "R6 pinned survives churn");
    xlate(32'h0010_1002, 1'b1, 32'h1000, "R6 pinned b survives churn");

    // R7: reload base; pinned keep old frame, others must walk the new table
    set_base(32'h0000_4000);
    xlate(32'h0010_0003, 1'b1, 32'h1000, "R7 pinned after reload");
    xlate(32'h0030_5004, 1'b0, 32'h4000, "R7 flushed entry walks new base");

    // R8: pin everything, misses are not kept
    for (int e = 0; e < 8; e++) pin(e, 1'b1);
    xlate(32'h0040_0123, 1'b0, 32'h4000, "R8 all pinned miss");
    xlate(32'h0040_0456, 1'b0, 32'h4000, "R8 not installed");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule